// File: doc/BRIEF.md
# Continuous-Phase AFSK Tone Generator

This block is a numerically controlled oscillator for audio frequency-shift keying. Each pulse on the sample strobe produces one signed 8-bit sine sample. The sample is read from a 128-entry sine table that is computed when the design is elaborated. A tone-select input picks the step size of a fixed-point phase accumulator. A value of 1 selects the 1200 Hz mark tone and a value of 0 selects the 2200 Hz space tone, both at a 13200 Hz sample rate.

The accumulator is never cleared when the tone changes, so the waveform stays continuous in phase across symbol edges. The block also counts samples per symbol, eleven of them for 1200 baud. It raises a symbol-done pulse together with the last sample of each symbol, which tells the upstream symbol source to present the next tone.

The output side is a valid-only stream: `sample_vld` marks a fresh sample for one cycle, and no ready input exists. The consumer must take every sample when it is offered, because the sample clock cannot be stalled. The strobe and the tone select are plain control pins.

Top module: `afsk_tone_gen`

## Requirements
- R1: After reset, and before the first strobe, `sample_out` is 0 and both `sample_vld` and `sym_done` are 0.
- R2: Each cycle with `sample_stb` high produces exactly one sample, with `sample_vld` high in the following cycle. A cycle without a strobe leaves `sample_vld` low in the next cycle, and `sample_out` holds its previous value.
- R3: A sample equals round(64·sin(2π·k/128)) as an 8-bit two's-complement value. Here k is the integer part, the top 7 bits, of the phase accumulator.
- R4: The table index k is taken from the phase before that strobe's increment is added, so the first sample after reset is the entry for k = 0, which is 0.
- R5: The phase is unsigned fixed point with 7 integer and 16 fractional bits. Each strobe adds 762601 when the effective tone is 1 (mark) and 1398101 when it is 0 (space). These are 1200·128·2^16/13200 and 2200·128·2^16/13200, each rounded to nearest.
- R6: The phase wraps modulo 128 table steps. It is not cleared or realigned when the tone changes.
- R7: `tone_sel` is sampled only on the first strobe of each symbol, and that value applies to all eleven samples of the symbol. Changes to it on the other ten strobes have no effect.
- R8: `sym_done` is high for one cycle, together with `sample_vld`, on every eleventh sample counted from reset. It is never high without `sample_vld`.
- R9: No sample has a magnitude above 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | Advances the oscillator by one sample |
| tone_sel | input | 1 | 1 = mark (1200 Hz), 0 = space (2200 Hz); sampled at symbol start |
| sample_out | output | 8 | Signed sine sample |
| sample_vld | output | 1 | Marks a new sample, one cycle after the strobe |
| sym_done | output | 1 | High with the valid of the last sample of a symbol |

## Verification
The bench concentrates on three places where a faulty design would go wrong:
- **Tone switches.** A design that cleared or realigned the phase at a switch would emit a jump back to the table entry for zero.
- **Tone select moving mid-symbol.** A design that sampled it on every strobe would change frequency partway through a symbol.
- **Wrap and gaps.** Long runs test the modulo-128 wrap together with the fractional carry, and a wrong step or a truncated fraction drifts away from the model within a few symbols. Gaps between strobes and strobes on consecutive cycles check that phase and output hold while idle and that no sample is lost.

A reset in the middle of a symbol checks that the symbol count restarts and that the first sample is again zero.

// File: rtl/afsk_pkg.sv
package afsk_pkg;

  // Fixed-point phase step for a tone: hz * 2^(tbl_bits+frac_bits) / fs, rounded.
  function automatic longint unsigned tone_step(input longint unsigned hz,
                                                input longint unsigned fs,
                                                input int unsigned     tbl_bits,
                                                input int unsigned     frac_bits);
    longint unsigned scaled;
    scaled = hz << (tbl_bits + frac_bits);
    return (scaled + fs / 2) / fs;
  endfunction

endpackage

// File: rtl/afsk_sine_rom.sv
module afsk_sine_rom #(
  parameter int IDX_W    = 7,
  parameter int SAMPLE_W = 8,
  parameter int AMP      = 64
) (
  input  logic [IDX_W-1:0]           idx,
  output logic signed [SAMPLE_W-1:0] value
);
  localparam int  DEPTH = 1 << IDX_W;
  localparam real TWO_PI = 6.283185307179586;

  function automatic logic signed [SAMPLE_W-1:0] sine_entry(input int k);
    real a;
    int  r;
    a = real'(AMP) * $sin(TWO_PI * real'(k) / real'(DEPTH));
    if (a >= 0.0) r = $rtoi(a + 0.5);
    else          r = -$rtoi(0.5 - a);
    return SAMPLE_W'(r);
  endfunction

  logic signed [SAMPLE_W-1:0] table_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam logic signed [SAMPLE_W-1:0] ENTRY = sine_entry(g);
    assign table_q[g] = ENTRY;
  end

  assign value = table_q[idx];
endmodule

// File: rtl/afsk_phase_acc.sv
module afsk_phase_acc #(
  parameter int               IDX_W      = 7,
  parameter int               FRAC_W     = 16,
  parameter int               PH_W       = IDX_W + FRAC_W,
  parameter logic [PH_W-1:0]  MARK_STEP  = '0,
  parameter logic [PH_W-1:0]  SPACE_STEP = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             use_mark,
  output logic [IDX_W-1:0] idx
);
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] step;

  assign step = use_mark ? MARK_STEP : SPACE_STEP;
  // Integer part before this strobe's increment; natural wrap gives modulo table size.
  assign idx  = phase_q[PH_W-1 -: IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n)       phase_q <= '0;
    else if (advance) phase_q <= phase_q + step;
  end
endmodule

// File: rtl/afsk_symbol_timer.sv
module afsk_symbol_timer #(
  parameter int SPS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  logic tone_in,
  output logic tone_eff,
  output logic last
);
  localparam int CNT_W = (SPS > 1) ? $clog2(SPS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SPS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tone_q;
  logic             first;

  assign first    = (cnt_q == '0);
  assign last     = (cnt_q == LAST_IDX);
  assign tone_eff = first ? tone_in : tone_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tone_q <= 1'b0;
    end else if (advance) begin
      if (first) tone_q <= tone_in;
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/afsk_tone_gen.sv
module afsk_tone_gen
  import afsk_pkg::*;
#(
  parameter int SAMPLE_HZ = 13200,
  parameter int MARK_HZ   = 1200,
  parameter int SPACE_HZ  = 2200,
  parameter int SPS       = 11,
  parameter int IDX_W     = 7,
  parameter int FRAC_W    = 16,
  parameter int SAMPLE_W  = 8,
  parameter int AMP       = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sample_stb,
  input  logic                       tone_sel,
  output logic signed [SAMPLE_W-1:0] sample_out,
  output logic                       sample_vld,
  output logic                       sym_done
);
  localparam int PH_W = IDX_W + FRAC_W;
  localparam logic [PH_W-1:0] MARK_STEP =
    PH_W'(tone_step(longint'(MARK_HZ), longint'(SAMPLE_HZ), IDX_W, FRAC_W));
  localparam logic [PH_W-1:0] SPACE_STEP =
    PH_W'(tone_step(longint'(SPACE_HZ), longint'(SAMPLE_HZ), IDX_W, FRAC_W));

  logic                       tone_eff;
  logic                       sym_last;
  logic [IDX_W-1:0]           idx;
  logic signed [SAMPLE_W-1:0] rom_value;

  afsk_symbol_timer #(.SPS(SPS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (sample_stb),
    .tone_in  (tone_sel),
    .tone_eff (tone_eff),
    .last     (sym_last)
  );

  afsk_phase_acc #(
    .IDX_W      (IDX_W),
    .FRAC_W     (FRAC_W),
    .PH_W       (PH_W),
    .MARK_STEP  (MARK_STEP),
    .SPACE_STEP (SPACE_STEP)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (sample_stb),
    .use_mark (tone_eff),
    .idx      (idx)
  );

  afsk_sine_rom #(
    .IDX_W    (IDX_W),
    .SAMPLE_W (SAMPLE_W),
    .AMP      (AMP)
  ) u_rom (
    .idx   (idx),
    .value (rom_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_out <= '0;
      sample_vld <= 1'b0;
      sym_done   <= 1'b0;
    end else begin
      sample_vld <= sample_stb;
      sym_done   <= sample_stb & sym_last;
      if (sample_stb) sample_out <= rom_value;
    end
  end
endmodule

// File: rtl/afsk_tone_chk.sv
module afsk_tone_chk #(
  parameter int SPS      = 11,
  parameter int SAMPLE_W = 8,
  parameter int AMP      = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sample_stb,
  input logic signed [SAMPLE_W-1:0] sample_out,
  input logic                       sample_vld,
  input logic                       sym_done
);
  localparam int CW = $clog2(SPS + 1) + 1;
  logic [CW-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         seen_q <= '0;
    else if (sym_done)  seen_q <= '0;
    else if (sample_vld) seen_q <= seen_q + 1'b1;
  end

  AST_VLD_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> sample_vld);  // R2
  AST_IDLE_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> (!sample_vld && $stable(sample_out)));  // R2
  AST_DONE_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    sym_done |-> sample_vld);  // R8
  AST_DONE_ON_ELEVENTH: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |-> (sym_done == (seen_q == CW'(SPS - 1))));  // R8
  AST_AMPLITUDE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |-> (sample_out <= SAMPLE_W'(AMP) && sample_out >= -SAMPLE_W'(AMP)));  // R9
endmodule

bind afsk_tone_gen afsk_tone_chk #(
  .SPS      (SPS),
  .SAMPLE_W (SAMPLE_W),
  .AMP      (AMP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_stb (sample_stb),
  .sample_out (sample_out),
  .sample_vld (sample_vld),
  .sym_done   (sym_done)
);

// File: tb/afsk_tone_gen_test.sv
module afsk_tone_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam longint MARK_INC  = 762601;   // R5
  localparam longint SPACE_INC = 1398101;  // R5
  localparam longint PH_MOD    = 64'd1 << 23;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sample_stb = 1'b0;
  logic              tone_sel = 1'b0;
  logic signed [7:0] sample_out;
  logic              sample_vld;
  logic              sym_done;

  int checks = 0;
  int fails  = 0;
  bit monitor_on = 1'b0;

  typedef struct packed { logic signed [7:0] val; logic done; } exp_t;
  exp_t exp_q[$];

  int     tbl [128];
  longint m_phase;
  int     m_cnt;
  bit     m_tone;
  logic signed [7:0] last_out;
  bit [15:0] lfsr = 16'hACE1;

  afsk_tone_gen uut (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .tone_sel(tone_sel),
    .sample_out(sample_out), .sample_vld(sample_vld), .sym_done(sym_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic fail_msg(input string req, input string what, input int act, input int exp);
    fails++;
    $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) fail_msg(req, what, act, exp);
  endtask

  task automatic model_reset();
    m_phase = 0; m_cnt = 0; m_tone = 1'b0;
  endtask

  // Driver: one strobe with given tone; pushes the expected sample (R3 R4 R5 R6 R7 R8)
  task automatic strobe(input bit tone);
    exp_t e;
    bit   eff;
    @(negedge clk);
    sample_stb = 1'b1;
    tone_sel   = tone;
    eff = (m_cnt == 0) ? tone : m_tone;
    if (m_cnt == 0) m_tone = tone;
    e.val  = 8'(tbl[int'(m_phase >> 16)]);
    e.done = (m_cnt == 10);
    exp_q.push_back(e);
    m_phase = (m_phase + (eff ? MARK_INC : SPACE_INC)) % PH_MOD;
    m_cnt   = (m_cnt == 10) ? 0 : m_cnt + 1;
  endtask

  task automatic idle(input int n, input bit tone);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample_stb = 1'b0;
      tone_sel   = tone;
    end
  endtask

  function automatic bit next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (monitor_on) begin
      if (sample_vld) begin
        if (exp_q.size() == 0) begin
          checks++;
          fail_msg("R2", "unexpected sample", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check("R3", "sample value", int'(sample_out), int'(e.val));
          check("R8", "symbol done", int'(sym_done), int'(e.done));
          if (sample_out > 64 || sample_out < -64) begin
            checks++;
            fail_msg("R9", "amplitude", int'(sample_out), 64);
          end
        end
        last_out = sample_out;
      end else begin
        check("R2", "output held while idle", int'(sample_out), int'(last_out));
        check("R8", "done without valid", int'(sym_done), 0);
      end
    end
  end

  task automatic do_reset();
    monitor_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b0; sample_stb = 1'b0;
    repeat (3) @(negedge clk);
    exp_q.delete();
    model_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "sample after reset", int'(sample_out), 0);
    check("R1", "valid after reset", int'(sample_vld), 0);
    check("R1", "done after reset", int'(sym_done), 0);
    last_out = 8'sd0;
    monitor_on = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      real a;
      a = 64.0 * $sin(6.283185307179586 * real'(i) / 128.0);
      tbl[i] = (a >= 0.0) ? $rtoi(a + 0.5) : -$rtoi(0.5 - a);
    end
    model_reset();
    last_out = 8'sd0;

    do_reset();

    // R4: first sample from index 0; strobes in consecutive cycles
    begin
      bit pat [10] = '{1, 0, 0, 1, 1, 1, 0, 1, 0, 0};
      for (int s = 0; s < 10; s++)
        for (int k = 0; k < 11; k++) strobe(pat[s]);
    end
    idle(3, 1'b0);

    // R7: tone select toggled on every non-first strobe of a symbol
    for (int s = 0; s < 6; s++)
      for (int k = 0; k < 11; k++) strobe((k == 0) ? s[0] : ~((k[0]) ^ s[0]));
    idle(2, 1'b1);

    // R2 R6: gaps between strobes with the tone select moving while idle
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 11; k++) begin
        strobe(s[1]);
        idle(k % 3, ~s[1]);
      end
    idle(2, 1'b0);

    // R6: long run exercising wrap and fractional carry
    for (int s = 0; s < 300; s++)
      for (int k = 0; k < 11; k++) strobe(next_bit());
    idle(3, 1'b0);

    // R1 R4 R8: reset in the middle of a symbol restarts count and phase
    for (int k = 0; k < 5; k++) strobe(1'b1);
    idle(2, 1'b0);
    do_reset();
    for (int s = 0; s < 3; s++)
      for (int k = 0; k < 11; k++) strobe(s[0]);
    idle(4, 1'b0);

    check("R2", "samples left unseen", exp_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule